// File: doc/BRIEF.md
# Vectored interrupt request controller

This block gathers five interrupt requests and turns them into a single vectored request towards a processor core. Two requests come from active-low external pins, two from timer overflow flags and one from a serial port flag. Each request is gated by its own enable bit and by a master enable bit. The highest-ranked pending request is presented as a vector number together with a request line.

The block holds an enable register and a small control register. For each external pin, the control register has a trigger-mode bit and a latched edge flag. An external request can follow the pin level, or it can be latched on a falling edge. An edge flag clears itself when the core acknowledges that vector. After an acknowledge the block issues nothing further until the core reports a return from interrupt. Priority levels and nesting are outside its scope, as are the timers and the serial port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The enable register (`en_rd`) has these bits: bit 0 enables external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial and bit 7 is the master enable. Bits 5 and 6 read 0 and ignore writes, so writing 0xFF reads back 0x9F.
- R2: While the master enable (bit 7) is 0, `irq_req` stays 0 whatever is pending.
- R3: A pending source whose own enable bit is 0 raises no request.
- R4: Vector numbers are 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial.
- R5: When several enabled requests are pending at once, the lowest vector number is issued.
- R6: The control register (`ctl_rd`) has these bits: bit 0 is the external 0 mode, bit 1 the external 0 edge flag, bit 2 the external 1 mode and bit 3 the external 1 edge flag. Bits 7..4 read 0, so writing 0xFF reads back 0x0F.
- R7: With mode 0 (level), an external request is present while the synchronized pin is low and goes away when the pin returns high. Its edge flag stays 0.
- R8: With mode 1 (edge), a high-to-low transition of the synchronized pin sets that source's flag, and the flag raises the request.
- R9: An acknowledge of vector 0 or vector 2 clears the matching edge flag.
- R10: After an acknowledge, `irq_req` stays 0 until `irq_reti` is pulsed. After that, pending requests are issued again.
- R11: After reset, both registers read 0 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_n | input | 1 | External request 0, active low, asynchronous |
| ext1_n | input | 1 | External request 1, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_irq | input | 1 | Serial port flag |
| en_wr | input | 1 | Write strobe for the enable register |
| ctl_wr | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data |
| en_rd | output | 8 | Enable register contents |
| ctl_rd | output | 8 | Control register contents |
| irq_req | output | 1 | Request towards the core, registered |
| irq_vec | output | 3 | Vector number of the request, registered |
| irq_ack | input | 1 | Core accepts the current vector |
| irq_reti | input | 1 | Core has left the service routine |

## Verification
The bench builds the block with its default two-stage pin synchronizer and three-bit vector. This puts the falling-edge path within a handful of cycles, so short pin pulses can be followed through the synchronizer, the edge flag and the registered request. The tests hold several sources pending together in order to exercise the fixed ranking. They also exercise masking by the master and individual enables, and check that a level request is not latched. An acknowledge and return pair is run while a source stays asserted, which shows the request staying quiet during service and returning afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int REG_W   = 8;
  localparam int GLB_BIT = 7;

  typedef enum logic [2:0] {
    VEC_EXT0 = 3'd0,
    VEC_TMR0 = 3'd1,
    VEC_EXT1 = 3'd2,
    VEC_TMR1 = 3'd3,
    VEC_SER  = 3'd4
  } irq_vec_e;

  // bits of the enable register that hold state
  localparam logic [REG_W-1:0] EN_MASK = 8'h9F;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/irq_ext_channel.sv
module irq_ext_channel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic mode,       // 0 level, 1 falling edge
  input  logic flag_wr,
  input  logic flag_wval,
  input  logic ack_clr,
  output logic req,
  output logic flag
);
  logic pin_s;
  logic pin_prev;
  logic fall;

  irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_n), .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b1;
    else     pin_prev <= pin_s;
  end

  assign fall = pin_prev & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst)                flag <= 1'b0;
    else if (mode && fall)  flag <= 1'b1;
    else if (ack_clr)       flag <= 1'b0;
    else if (flag_wr)       flag <= flag_wval;
  end

  assign req = mode ? flag : ~pin_s;

  AST_EDGE_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
    (ack_clr && !(mode && fall) && !flag_wr) |=> !flag); // R9
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = $clog2(irq_pkg::NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ext0_n,
  input  logic                     ext1_n,
  input  logic                     tmr0_ovf,
  input  logic                     tmr1_ovf,
  input  logic                     ser_irq,
  input  logic                     en_wr,
  input  logic                     ctl_wr,
  input  logic [irq_pkg::REG_W-1:0] wdata,
  output logic [irq_pkg::REG_W-1:0] en_rd,
  output logic [irq_pkg::REG_W-1:0] ctl_rd,
  output logic                     irq_req,
  output logic [VEC_W-1:0]         irq_vec,
  input  logic                     irq_ack,
  input  logic                     irq_reti
);
  import irq_pkg::*;

  localparam int N = NUM_SRC;

  logic [REG_W-1:0] en_reg;
  logic [1:0]       mode;
  logic [1:0]       ext_req;
  logic [1:0]       ext_flag;
  logic [1:0]       ext_clr;
  logic [1:0]       ext_pin;
  logic [N-1:0]     raw;
  logic [N-1:0]     pend;
  logic             any_pend;
  logic [VEC_W-1:0] pick;
  logic             busy;
  logic             ack_fire;

  // enable register, reserved bits forced to zero
  always_ff @(posedge clk) begin
    if (rst)        en_reg <= '0;
    else if (en_wr) en_reg <= wdata & EN_MASK;
  end

  // trigger-mode bits (control bits 0 and 2)
  always_ff @(posedge clk) begin
    if (rst)         mode <= 2'b00;
    else if (ctl_wr) mode <= {wdata[2], wdata[0]};
  end

  assign ack_fire = irq_ack && irq_req && !busy;
  assign ext_pin  = {ext1_n, ext0_n};

  for (genvar c = 0; c < 2; c++) begin : g_ext
    assign ext_clr[c] = ack_fire && (irq_vec == VEC_W'(2*c));
    irq_ext_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .pin_n    (ext_pin[c]),
      .mode     (mode[c]),
      .flag_wr  (ctl_wr),
      .flag_wval(wdata[2*c+1]),
      .ack_clr  (ext_clr[c]),
      .req      (ext_req[c]),
      .flag     (ext_flag[c])
    );
  end

  assign raw  = {ser_irq, tmr1_ovf, ext_req[1], tmr0_ovf, ext_req[0]};
  assign pend = raw & en_reg[N-1:0] & {N{en_reg[GLB_BIT]}};

  irq_prio_pick #(.N(N), .IDX_W(VEC_W)) u_pick (
    .pend(pend), .any(any_pend), .idx(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (busy) begin
      irq_req <= 1'b0;
      if (irq_reti) busy <= 1'b0;
    end else if (ack_fire) begin
      busy    <= 1'b1;
      irq_req <= 1'b0;
    end else begin
      irq_req <= any_pend;
      if (any_pend) irq_vec <= pick;
    end
  end

  assign en_rd  = en_reg;
  assign ctl_rd = {4'b0000, ext_flag[1], mode[1], ext_flag[0], mode[0]};

  AST_REQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(en_reg[GLB_BIT])); // R2
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) < N)); // R4
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any_pend |-> (pend[pick] && ((pend & N'((N'(1) << pick) - N'(1))) == '0))); // R5
  AST_QUIET_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack_fire || (busy && !irq_reti)) |=> !irq_req); // R10
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext0_n = 1'b1, ext1_n = 1'b1;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, ser_irq = 1'b0;
  logic       en_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] en_rd, ctl_rd;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack = 1'b0, irq_reti = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .ser_irq(ser_irq),
    .en_wr(en_wr), .ctl_wr(ctl_wr), .wdata(wdata),
    .en_rd(en_rd), .ctl_rd(ctl_rd), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ext0_n = 1'b1; ext1_n = 1'b1;
    tmr0_ovf = 1'b0; tmr1_ovf = 1'b0; ser_irq = 1'b0;
    en_wr = 1'b0; ctl_wr = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
    step(4);
    rst = 1'b0;
    step(1);
  endtask

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_wr = 1'b1; wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); irq_reti = 1'b1;
    @(negedge clk); irq_reti = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 en_rd after reset", int'(en_rd), 0);
    chk("R11 ctl_rd after reset", int'(ctl_rd), 0);
    chk("R11 irq_req after reset", int'(irq_req), 0);
  endtask

  task automatic t_regs();
    do_reset();
    wr_en(8'hFF);
    chk("R1 enable readback", int'(en_rd), 'h9F);
    do_reset();
    wr_ctl(8'hFF);
    chk("R6 control readback", int'(ctl_rd), 'h0F);
  endtask

  task automatic t_global();
    do_reset();
    tmr0_ovf = 1'b1;
    wr_en(8'h1F);
    step(3);
    chk("R2 no request without master", int'(irq_req), 0);
    wr_en(8'h9F);
    step(3);
    chk("R2 request with master", int'(irq_req), 1);
    chk("R4 timer0 vector", int'(irq_vec), 1);
  endtask

  task automatic t_enable();
    do_reset();
    tmr1_ovf = 1'b1; ser_irq = 1'b1;
    wr_en(8'h90);
    step(3);
    chk("R3 serial only enabled req", int'(irq_req), 1);
    chk("R4 serial vector", int'(irq_vec), 4);
    wr_en(8'h88);
    step(3);
    chk("R4 timer1 vector", int'(irq_vec), 3);
    wr_en(8'h80);
    step(3);
    chk("R3 no request when sources disabled", int'(irq_req), 0);
  endtask

  task automatic t_prio();
    do_reset();
    ser_irq = 1'b1; tmr1_ovf = 1'b1; tmr0_ovf = 1'b1;
    wr_en(8'h9F);
    step(3);
    chk("R5 lowest of 1,3,4", int'(irq_vec), 1);
    tmr0_ovf = 1'b0;
    step(3);
    chk("R5 lowest of 3,4", int'(irq_vec), 3);
  endtask

  task automatic t_level();
    do_reset();
    wr_en(8'h84);
    ext1_n = 1'b0;
    step(5);
    chk("R7 level request present", int'(irq_req), 1);
    chk("R4 external1 vector", int'(irq_vec), 2);
    chk("R7 level flag stays clear", int'(ctl_rd[3]), 0);
    ext1_n = 1'b1;
    step(5);
    chk("R7 level request released", int'(irq_req), 0);
  endtask

  task automatic t_edge();
    do_reset();
    wr_ctl(8'h01);
    wr_en(8'h81);
    ext0_n = 1'b0;
    step(3);
    ext0_n = 1'b1;
    step(6);
    chk("R8 edge flag set", int'(ctl_rd), 'h03);
    chk("R8 edge request", int'(irq_req), 1);
    chk("R4 external0 vector", int'(irq_vec), 0);
    pulse_ack();
    step(2);
    chk("R9 flag cleared by ack", int'(ctl_rd), 'h01);
    pulse_reti();
    step(4);
    chk("R9 no request after clear", int'(irq_req), 0);
  endtask

  task automatic t_service();
    do_reset();
    tmr0_ovf = 1'b1;
    wr_en(8'h82);
    step(3);
    chk("R10 initial request", int'(irq_req), 1);
    pulse_ack();
    step(6);
    chk("R10 quiet during service", int'(irq_req), 0);
    pulse_reti();
    step(3);
    chk("R10 request after return", int'(irq_req), 1);
    chk("R10 vector after return", int'(irq_vec), 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_global();
    t_enable();
    t_prio();
    t_level();
    t_edge();
    t_service();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule